// File: doc/BRIEF.md
# Interruption State Capture Unit

This block sits in a processor core and owns the execution context that must survive an interruption. It keeps the live status word and a two-entry program-counter queue (front = address now executing, back = the one after it). When an interruption is taken, it can copy that context into a set of shadow registers. Those are a saved status word, a saved front/back address pair, and a fault status/fault address pair that describe the event. It then steers the queue to the handler's vector. A return command reloads the live context from the shadow registers.

Whether a capture happens depends on one collection-enable bit (Q, bit `Q_POS` of the status word). A small two-state machine holds that bit. In `MODE_COLLECT` (Q = 1) an interruption captures the context, then the transition *trap* moves the machine to `MODE_HOLD` (Q = 0). In `MODE_HOLD` a further interruption still redirects the queue, but it captures nothing. The saved context from the first event therefore stays intact. The transition *return* takes the machine to the mode given by Q in the saved status word. The transition *status write* takes it to the mode given by Q in the written data. No other event changes the mode.

A register port lets handler software read every register and write the shadow registers. It can therefore build a context and return into it, resuming at any address it likes.

Top module: `intr_ctx_unit`

## Requirements
- R1: An interruption taken while Q = 1 copies the live status word (with Q = 1) into the saved status register, and copies the live front and back addresses into the saved address pair.
- R2: Every taken interruption clears Q in the live status word and leaves all other status bits unchanged.
- R3: An interruption taken while Q = 0 leaves the saved status register and the saved address pair unchanged.
- R4: The fault status and fault address registers load `intr_fstat` and `intr_faddr` only on an interruption taken with Q = 1.
- R5: A return command loads the live status word, front and back from the saved registers in one cycle. Execution then continues at the restored front address.
- R6: After software writes the saved registers (with Q set in the saved status) and issues a return, Q is 1 and the front address equals the written saved front.
- R7: On an interruption, front becomes `VEC_BASE + (intr_num << 5)` and back becomes that value plus 4.
- R8: When an interruption request and a return command arrive in the same cycle, the interruption is taken and the return is dropped.
- R9: Register port select codes are: 0 live status, 1 saved status, 2 saved front, 3 saved back, 4 fault status, 5 fault address, 6 live front, 7 live back. Codes 6 and 7 are read-only. A write in a cycle with an interruption or return request is dropped.
- R10: A step request moves back into front and loads `step_addr` into back. A step in a cycle with an interruption or return request is dropped.
- R11: After reset every register (live and saved) reads 0 and Q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_req | input | 1 | Take an interruption this cycle |
| intr_num | input | NUM_W | Interruption number, selects vector |
| intr_fstat | input | DW | Fault status accompanying the interruption |
| intr_faddr | input | DW | Fault address accompanying the interruption |
| rfi_req | input | 1 | Return-from-interrupt command |
| step_req | input | 1 | Advance the program-counter queue |
| step_addr | input | DW | Address entering the back of the queue |
| reg_we | input | 1 | Register port write strobe |
| reg_sel | input | 3 | Register port select |
| reg_wdata | input | DW | Register port write data |
| reg_rdata | output | DW | Register port read data (combinational) |
| psw | output | DW | Live status word |
| pc_front | output | DW | Live front address |
| pc_back | output | DW | Live back address |

## Verification
The hardest situation to reach from the ports is a second interruption that lands while Q is already 0. This is the case in which the saved context must survive untouched. The stimulus reaches it by first setting Q through a live-status write, taking one interruption, and then taking another with different fault data before any return. After that it reads every shadow register back. The collisions between a register write and a capture, and between a return and an interruption, are driven in single cycles. The results are then read back through the port.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

    // Event class decided once per cycle by the arbiter.
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_TRAP   = 2'd1,
        EV_RETURN = 2'd2
    } ev_kind_e;

    // Collection mode; mirrors the Q bit of the live status word.
    typedef enum logic {
        MODE_HOLD    = 1'b0,
        MODE_COLLECT = 1'b1
    } mode_e;

    // Register port select codes.
    typedef enum logic [2:0] {
        SEL_PSW    = 3'd0,
        SEL_SPSW   = 3'd1,
        SEL_SFRONT = 3'd2,
        SEL_SBACK  = 3'd3,
        SEL_FSTAT  = 3'd4,
        SEL_FADDR  = 3'd5,
        SEL_FRONT  = 3'd6,
        SEL_BACK   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/ctx_event_arb.sv
module ctx_event_arb
    import ctx_pkg::*;
(
    input  logic     intr_req,
    input  logic     rfi_req,
    input  logic     step_req,
    input  logic     reg_we,
    output ev_kind_e ev_kind,
    output logic     step_en,
    output logic     wr_en
);

    // Interruption outranks return; both block steps and port writes.
    always_comb begin
        ev_kind = EV_NONE;
        if (intr_req) begin
            ev_kind = EV_TRAP;
        end else if (rfi_req) begin
            ev_kind = EV_RETURN;
        end
        step_en = step_req && (ev_kind == EV_NONE);
        wr_en   = reg_we   && (ev_kind == EV_NONE);
    end

endmodule

// File: rtl/ctx_mode_fsm.sv
module ctx_mode_fsm
    import ctx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ev_kind_e ev_kind,
    input  logic     psw_wr,
    input  logic     psw_wr_q,
    input  logic     saved_q,
    output logic     q_on,
    output logic     capture
);

    mode_e state_q;
    mode_e state_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MODE_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: trap, return, status write.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_HOLD: begin
                if (ev_kind == EV_RETURN) begin
                    if (saved_q) state_d = MODE_COLLECT;
                end else if (psw_wr && psw_wr_q) begin
                    state_d = MODE_COLLECT;
                end
            end
            MODE_COLLECT: begin
                if (ev_kind == EV_TRAP) begin
                    state_d = MODE_HOLD;
                end else if (ev_kind == EV_RETURN) begin
                    if (!saved_q) state_d = MODE_HOLD;
                end else if (psw_wr && !psw_wr_q) begin
                    state_d = MODE_HOLD;
                end
            end
            default: state_d = MODE_HOLD;
        endcase
    end

    // Outputs.
    always_comb begin
        q_on    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            MODE_HOLD: begin
                q_on    = 1'b0;
                capture = 1'b0;
            end
            MODE_COLLECT: begin
                q_on    = 1'b1;
                capture = (ev_kind == EV_TRAP);
            end
            default: begin
                q_on    = 1'b0;
                capture = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank
    import ctx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] live_psw,
    input  logic [DW-1:0] live_front,
    input  logic [DW-1:0] live_back,
    input  logic [DW-1:0] fstat_in,
    input  logic [DW-1:0] faddr_in,
    input  logic          wr_en,
    input  reg_sel_e      wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] saved_psw,
    output logic [DW-1:0] saved_front,
    output logic [DW-1:0] saved_back,
    output logic [DW-1:0] fault_stat,
    output logic [DW-1:0] fault_addr
);

    localparam int NSLOT = 5;

    logic [DW-1:0] cap_val [NSLOT];
    logic [DW-1:0] cur_val [NSLOT];
    reg_sel_e      slot_sel [NSLOT];

    assign cap_val[0] = live_psw;
    assign cap_val[1] = live_front;
    assign cap_val[2] = live_back;
    assign cap_val[3] = fstat_in;
    assign cap_val[4] = faddr_in;

    assign slot_sel[0] = SEL_SPSW;
    assign slot_sel[1] = SEL_SFRONT;
    assign slot_sel[2] = SEL_SBACK;
    assign slot_sel[3] = SEL_FSTAT;
    assign slot_sel[4] = SEL_FADDR;

    // One register per slot; capture outranks a port write.
    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_val[gi] <= '0;
            end else if (capture) begin
                cur_val[gi] <= cap_val[gi];
            end else if (wr_en && (wr_sel == slot_sel[gi])) begin
                cur_val[gi] <= wr_data;
            end
        end
    end

    assign saved_psw   = cur_val[0];
    assign saved_front = cur_val[1];
    assign saved_back  = cur_val[2];
    assign fault_stat  = cur_val[3];
    assign fault_addr  = cur_val[4];

endmodule

// File: rtl/ctx_live_state.sv
module ctx_live_state
    import ctx_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          NUM_W      = 5,
    parameter int          VEC_SHIFT  = 5,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] VEC_BASE   = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ev_kind_e         ev_kind,
    input  logic [NUM_W-1:0] intr_num,
    input  logic             step_en,
    input  logic [DW-1:0]    step_addr,
    input  logic             psw_wr,
    input  logic [DW-1:0]    psw_wdata,
    input  logic [DW-1:0]    saved_psw,
    input  logic [DW-1:0]    saved_front,
    input  logic [DW-1:0]    saved_back,
    output logic [DW-1:0]    psw_raw,
    output logic [DW-1:0]    front,
    output logic [DW-1:0]    back
);

    localparam logic [DW-1:0] BASE_W = DW'(VEC_BASE);
    localparam logic [DW-1:0] STEP_W = DW'(INSN_BYTES);

    logic [DW-1:0] vec_addr;

    assign vec_addr = BASE_W + (DW'(intr_num) << VEC_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psw_raw <= '0;
            front   <= '0;
            back    <= '0;
        end else begin
            unique case (ev_kind)
                EV_TRAP: begin
                    front <= vec_addr;
                    back  <= vec_addr + STEP_W;
                end
                EV_RETURN: begin
                    psw_raw <= saved_psw;
                    front   <= saved_front;
                    back    <= saved_back;
                end
                EV_NONE: begin
                    if (step_en) begin
                        front <= back;
                        back  <= step_addr;
                    end
                    if (psw_wr) begin
                        psw_raw <= psw_wdata;
                    end
                end
                default: begin
                    psw_raw <= psw_raw;
                end
            endcase
        end
    end

endmodule

// File: rtl/intr_ctx_unit.sv
module intr_ctx_unit
    import ctx_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          NUM_W      = 5,
    parameter int          Q_POS      = 3,
    parameter int          VEC_SHIFT  = 5,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] VEC_BASE   = 32'h0000_1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             intr_req,
    input  logic [NUM_W-1:0] intr_num,
    input  logic [DW-1:0]    intr_fstat,
    input  logic [DW-1:0]    intr_faddr,
    input  logic             rfi_req,
    input  logic             step_req,
    input  logic [DW-1:0]    step_addr,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [DW-1:0]    psw,
    output logic [DW-1:0]    pc_front,
    output logic [DW-1:0]    pc_back
);

    localparam logic [DW-1:0] Q_MASK = DW'(1) << Q_POS;

    ev_kind_e      ev_kind;
    logic          step_en;
    logic          wr_en;
    logic          psw_wr;
    logic          q_on;
    logic          capture;
    reg_sel_e      sel_e;
    logic [DW-1:0] psw_raw;
    logic [DW-1:0] saved_psw;
    logic [DW-1:0] saved_front;
    logic [DW-1:0] saved_back;
    logic [DW-1:0] fault_stat;
    logic [DW-1:0] fault_addr;

    assign sel_e  = reg_sel_e'(reg_sel);
    assign psw_wr = wr_en && (sel_e == SEL_PSW);

    ctx_event_arb u_arb (
        .intr_req (intr_req),
        .rfi_req  (rfi_req),
        .step_req (step_req),
        .reg_we   (reg_we),
        .ev_kind  (ev_kind),
        .step_en  (step_en),
        .wr_en    (wr_en)
    );

    ctx_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_kind  (ev_kind),
        .psw_wr   (psw_wr),
        .psw_wr_q (reg_wdata[Q_POS]),
        .saved_q  (saved_psw[Q_POS]),
        .q_on     (q_on),
        .capture  (capture)
    );

    ctx_live_state #(
        .DW         (DW),
        .NUM_W      (NUM_W),
        .VEC_SHIFT  (VEC_SHIFT),
        .INSN_BYTES (INSN_BYTES),
        .VEC_BASE   (VEC_BASE)
    ) u_live (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_kind     (ev_kind),
        .intr_num    (intr_num),
        .step_en     (step_en),
        .step_addr   (step_addr),
        .psw_wr      (psw_wr),
        .psw_wdata   (reg_wdata),
        .saved_psw   (saved_psw),
        .saved_front (saved_front),
        .saved_back  (saved_back),
        .psw_raw     (psw_raw),
        .front       (pc_front),
        .back        (pc_back)
    );

    // Q bit of the visible status word comes from the mode machine.
    assign psw = (psw_raw & ~Q_MASK) | (q_on ? Q_MASK : '0);

    ctx_shadow_bank #(
        .DW (DW)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (capture),
        .live_psw    (psw),
        .live_front  (pc_front),
        .live_back   (pc_back),
        .fstat_in    (intr_fstat),
        .faddr_in    (intr_faddr),
        .wr_en       (wr_en),
        .wr_sel      (sel_e),
        .wr_data     (reg_wdata),
        .saved_psw   (saved_psw),
        .saved_front (saved_front),
        .saved_back  (saved_back),
        .fault_stat  (fault_stat),
        .fault_addr  (fault_addr)
    );

    always_comb begin
        unique case (sel_e)
            SEL_PSW:    reg_rdata = psw;
            SEL_SPSW:   reg_rdata = saved_psw;
            SEL_SFRONT: reg_rdata = saved_front;
            SEL_SBACK:  reg_rdata = saved_back;
            SEL_FSTAT:  reg_rdata = fault_stat;
            SEL_FADDR:  reg_rdata = fault_addr;
            SEL_FRONT:  reg_rdata = pc_front;
            SEL_BACK:   reg_rdata = pc_back;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intr_ctx_unit_chk.sv
module intr_ctx_unit_chk #(
    parameter int          DW         = 32,
    parameter int          NUM_W      = 5,
    parameter int          Q_POS      = 3,
    parameter int          VEC_SHIFT  = 5,
    parameter int          INSN_BYTES = 4,
    parameter logic [31:0] VEC_BASE   = 32'h0000_1000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             intr_req,
    input logic [NUM_W-1:0] intr_num,
    input logic [DW-1:0]    intr_fstat,
    input logic [DW-1:0]    intr_faddr,
    input logic             rfi_req,
    input logic [DW-1:0]    psw,
    input logic [DW-1:0]    pc_front,
    input logic [DW-1:0]    pc_back,
    input logic [DW-1:0]    saved_psw,
    input logic [DW-1:0]    saved_front,
    input logic [DW-1:0]    saved_back,
    input logic [DW-1:0]    fault_stat,
    input logic [DW-1:0]    fault_addr
);

    localparam logic [DW-1:0] Q_MASK = DW'(1) << Q_POS;

    a_r1_capture_ctx: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req && psw[Q_POS] |=> saved_psw == $past(psw)
            && saved_front == $past(pc_front) && saved_back == $past(pc_back));

    a_r2_q_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req |=> !psw[Q_POS] && ((psw & ~Q_MASK) == ($past(psw) & ~Q_MASK)));

    a_r3_nested_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req && !psw[Q_POS] |=> $stable(saved_psw) && $stable(saved_front)
            && $stable(saved_back));

    a_r4_fault_load: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req && psw[Q_POS] |=> fault_stat == $past(intr_fstat)
            && fault_addr == $past(intr_faddr));

    a_r4_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req && !psw[Q_POS] |=> $stable(fault_stat) && $stable(fault_addr));

    a_r5_restore: assert property (@(posedge clk) disable iff (!rst_n)
        rfi_req && !intr_req |=> psw == $past(saved_psw)
            && pc_front == $past(saved_front) && pc_back == $past(saved_back));

    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        intr_req |=> pc_front == DW'(VEC_BASE) + (DW'($past(intr_num)) << VEC_SHIFT)
            && pc_back == pc_front + DW'(INSN_BYTES));

endmodule

bind intr_ctx_unit intr_ctx_unit_chk #(
    .DW         (DW),
    .NUM_W      (NUM_W),
    .Q_POS      (Q_POS),
    .VEC_SHIFT  (VEC_SHIFT),
    .INSN_BYTES (INSN_BYTES),
    .VEC_BASE   (VEC_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .intr_req    (intr_req),
    .intr_num    (intr_num),
    .intr_fstat  (intr_fstat),
    .intr_faddr  (intr_faddr),
    .rfi_req     (rfi_req),
    .psw         (psw),
    .pc_front    (pc_front),
    .pc_back     (pc_back),
    .saved_psw   (saved_psw),
    .saved_front (saved_front),
    .saved_back  (saved_back),
    .fault_stat  (fault_stat),
    .fault_addr  (fault_addr)
);

// File: tb/intr_ctx_unit_bench.sv
`timescale 1ns/1ps
module intr_ctx_unit_bench;

    localparam int DW = 32;
    localparam int NUM_W = 5;

    // Operations applied for one clock.
    localparam logic [2:0] OP_NOP = 3'd0, OP_STEP = 3'd1, OP_INTR = 3'd2, OP_RFI = 3'd3,
                           OP_WR = 3'd4, OP_WR_INTR = 3'd5, OP_INTR_RFI = 3'd6,
                           OP_STEP_INTR = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [4:0]  num;
        logic [2:0]  sel;
        logic [31:0] a;
        logic [31:0] b;
        logic [2:0]  csel;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t TBL [NV] = '{
        '{OP_WR,   5'd0, 3'd0, 32'hA8, 32'h0, 3'd0, 32'hA8, 8'd9},          // R9 live status write, Q on
        '{OP_STEP, 5'd0, 3'd0, 32'h100, 32'h0, 3'd7, 32'h100, 8'd10},       // R10
        '{OP_STEP, 5'd0, 3'd0, 32'h104, 32'h0, 3'd6, 32'h100, 8'd10},       // R10
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd7, 32'h104, 8'd10},         // R10
        '{OP_INTR, 5'd3, 3'd0, 32'h11, 32'hDEAD0000, 3'd0, 32'hA0, 8'd2},   // R2
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd1, 32'hA8, 8'd1},           // R1
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd2, 32'h100, 8'd1},          // R1
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd3, 32'h104, 8'd1},          // R1
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd4, 32'h11, 8'd4},           // R4
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd5, 32'hDEAD0000, 8'd4},     // R4
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd6, 32'h1060, 8'd7},         // R7
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd7, 32'h1064, 8'd7},         // R7
        '{OP_INTR, 5'd7, 3'd0, 32'h22, 32'hBEEF, 3'd1, 32'hA8, 8'd3},       // R3 nested
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd2, 32'h100, 8'd3},          // R3
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd3, 32'h104, 8'd3},          // R3
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd4, 32'h11, 8'd4},           // R4 hold
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd5, 32'hDEAD0000, 8'd4},     // R4 hold
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd6, 32'h10E0, 8'd7},         // R7
        '{OP_RFI,  5'd0, 3'd0, 32'h0, 32'h0, 3'd0, 32'hA8, 8'd5},           // R5
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd6, 32'h100, 8'd5},          // R5
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd7, 32'h104, 8'd5},          // R5
        '{OP_WR,   5'd0, 3'd6, 32'h5555, 32'h0, 3'd6, 32'h100, 8'd9},       // R9 read-only
        '{OP_WR_INTR, 5'd1, 3'd1, 32'h77, 32'h33, 3'd1, 32'hA8, 8'd9},      // R9 capture beats write
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd6, 32'h1020, 8'd7},         // R7
        '{OP_WR,   5'd0, 3'd2, 32'h4000, 32'h0, 3'd2, 32'h4000, 8'd6},      // R6
        '{OP_WR,   5'd0, 3'd3, 32'h4004, 32'h0, 3'd3, 32'h4004, 8'd6},      // R6
        '{OP_WR,   5'd0, 3'd1, 32'h0C, 32'h0, 3'd1, 32'h0C, 8'd6},          // R6
        '{OP_RFI,  5'd0, 3'd0, 32'h0, 32'h0, 3'd0, 32'h0C, 8'd6},           // R6
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd6, 32'h4000, 8'd6},         // R6
        '{OP_INTR_RFI, 5'd2, 3'd0, 32'h0, 32'h0, 3'd6, 32'h1040, 8'd8},     // R8
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd0, 32'h04, 8'd8},           // R8
        '{OP_NOP,  5'd0, 3'd0, 32'h0, 32'h0, 3'd2, 32'h4000, 8'd8},         // R8
        '{OP_STEP, 5'd0, 3'd0, 32'h2000, 32'h0, 3'd6, 32'h1044, 8'd10},     // R10
        '{OP_STEP_INTR, 5'd0, 3'd0, 32'h9999, 32'h0, 3'd7, 32'h1004, 8'd10} // R10 step dropped
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             intr_req = 1'b0;
    logic [NUM_W-1:0] intr_num = '0;
    logic [DW-1:0]    intr_fstat = '0;
    logic [DW-1:0]    intr_faddr = '0;
    logic             rfi_req = 1'b0;
    logic             step_req = 1'b0;
    logic [DW-1:0]    step_addr = '0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_sel = '0;
    logic [DW-1:0]    reg_wdata = '0;
    logic [DW-1:0]    reg_rdata;
    logic [DW-1:0]    psw;
    logic [DW-1:0]    pc_front;
    logic [DW-1:0]    pc_back;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    intr_ctx_unit u_intr_ctx_unit (
        .clk (clk), .rst_n (rst_n), .intr_req (intr_req), .intr_num (intr_num),
        .intr_fstat (intr_fstat), .intr_faddr (intr_faddr), .rfi_req (rfi_req),
        .step_req (step_req), .step_addr (step_addr), .reg_we (reg_we),
        .reg_sel (reg_sel), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .psw (psw), .pc_front (pc_front), .pc_back (pc_back)
    );

    task automatic check(input int req, input logic [2:0] sel, input logic [31:0] exp);
        reg_sel = sel;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL R%0d sel %0d got %h expected %h", req, sel, reg_rdata, exp);
        end
    endtask

    task automatic run_op(input vec_t v);
        @(negedge clk);
        intr_num   = v.num;
        intr_fstat = v.a;
        intr_faddr = v.b;
        reg_sel    = v.sel;
        reg_wdata  = v.a;
        step_addr  = v.a;
        unique case (v.op)
            OP_STEP:      step_req = 1'b1;
            OP_INTR:      intr_req = 1'b1;
            OP_RFI:       rfi_req = 1'b1;
            OP_WR:        reg_we = 1'b1;
            OP_WR_INTR:   begin reg_we = 1'b1; intr_req = 1'b1; intr_fstat = v.b; end
            OP_INTR_RFI:  begin intr_req = 1'b1; rfi_req = 1'b1; end
            OP_STEP_INTR: begin step_req = 1'b1; intr_req = 1'b1; end
            default:      ;
        endcase
        @(posedge clk);
        #1;
        intr_req = 1'b0;
        rfi_req  = 1'b0;
        step_req = 1'b0;
        reg_we   = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R11: reset state of every register
        for (int s = 0; s < 8; s++) check(11, 3'(s), 32'h0);
        for (int i = 0; i < NV; i++) begin
            run_op(TBL[i]);
            check(int'(TBL[i].req), TBL[i].csel, TBL[i].exp);
        end
        // R11: reset in the middle of operation
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(11, 3'd0, 32'h0);
        check(11, 3'd2, 32'h0);
        check(11, 3'd6, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule